// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Overflow Flag

This block is a purely combinational integer arithmetic-logic unit for an execution stage. It takes two operands of `WIDTH` bits (32 by default) and a four-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a flag for signed overflow. The datapath is a row of identical one-bit cells. Each cell holds a full adder and a small output multiplexer, and the carry ripples from bit 0 to the top bit.

Subtraction uses the same adder. The cell inverts the B operand and the carry into bit 0 is forced to 1. Set-on-less-than uses the same subtract path. Its answer is the sign of the difference, corrected by the overflow condition, and it is placed in bit 0 of the result.

A separate `wrap_mode` input selects unsigned arithmetic. In this mode add and subtract still produce the same bits, but the overflow flag stays low so that no trap is raised downstream.

Top module: `alu_core`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of A and B.
- R2: Code 4'b0001 gives the bitwise OR of A and B.
- R3: Code 4'b0010 gives A + B modulo 2^WIDTH.
- R4: Code 4'b0110 gives A - B modulo 2^WIDTH, formed as A + ~B + 1.
- R5: Code 4'b0111 gives 1 in bit 0 when A is less than B as signed numbers, and 0 otherwise. All bits above bit 0 are 0.
- R6: For add with `wrap_mode` low, `ovf` is 1 exactly when two non-negative operands give a negative sum, or two negative operands give a non-negative sum.
- R7: For subtract with `wrap_mode` low, `ovf` is 1 exactly when a non-negative A minus a negative B gives a negative result, or a negative A minus a non-negative B gives a non-negative result.
- R8: An add of operands with different signs never sets `ovf`, and neither does a subtract of operands with equal signs.
- R9: With `wrap_mode` high, `ovf` is 0 for every code, and the result is the same as with `wrap_mode` low.
- R10: `is_zero` is 1 exactly when every result bit is 0.
- R11: Any code other than the five above gives a result of 0 and `ovf` of 0.
- R12: `ovf` is 0 for the AND, OR and set-on-less-than codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| wrap_mode | input | 1 | Unsigned mode, keeps `ovf` low |
| result | output | WIDTH | Operation result |
| is_zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow for add or subtract |

## Verification
Two things can happen in the same evaluation. The sign-overflow correction can change the set-on-less-than answer, and an overflowing add or subtract can also produce a zero result. In that second case `is_zero` and `ovf` are both high.

The first case is provoked by operand pairs near the signed limits, such as the most negative value against 1, or the most positive value against -1. There the raw sign of the difference is wrong and only the corrected value gives the right answer. The second case comes from adding the most negative value to itself.

A four-bit copy of the block is swept over every operand pair, every listed code and both modes. This makes sure every such collision occurs. Each output is judged against signed and unsigned arithmetic computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    typedef enum logic [2:0] {
        PICK_AND,
        PICK_OR,
        PICK_SUM,
        PICK_LESS,
        PICK_NONE
    } pick_e;

    typedef struct packed {
        logic  invert_b;   // feed ~B and carry-in 1
        logic  arith;      // overflow may be reported
        pick_e pick;       // per-slice output choice
    } ctrl_t;

    function automatic ctrl_t decode_op(input logic [3:0] code);
        ctrl_t c;
        c = '{invert_b: 1'b0, arith: 1'b0, pick: PICK_NONE};
        case (code)
            OP_AND: c.pick = PICK_AND;
            OP_OR:  c.pick = PICK_OR;
            OP_ADD: begin c.pick = PICK_SUM;  c.arith = 1'b1; end
            OP_SUB: begin c.pick = PICK_SUM;  c.arith = 1'b1; c.invert_b = 1'b1; end
            OP_SLT: begin c.pick = PICK_LESS; c.invert_b = 1'b1; end
            default: c.pick = PICK_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  cin,
    input  logic  invert_b,
    input  pick_e pick,
    input  logic  less,
    output logic  res,
    output logic  sum,
    output logic  b_eff,
    output logic  cout
);
    always_comb begin
        b_eff = b ^ invert_b;
        sum   = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (b_eff & cin) | (a & cin);
        case (pick)
            PICK_AND:  res = a & b;
            PICK_OR:   res = a | b;
            PICK_SUM:  res = sum;
            PICK_LESS: res = less;
            default:   res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    input  pick_e            pick,
    input  logic [WIDTH-1:0] less,
    output logic [WIDTH-1:0] res,
    output logic             msb_sum,
    output logic             msb_b_eff
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] beff_v;

    assign carry[0] = invert_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .cin      (carry[i]),
            .invert_b (invert_b),
            .pick     (pick),
            .less     (less[i]),
            .res      (res[i]),
            .sum      (sum_v[i]),
            .b_eff    (beff_v[i]),
            .cout     (carry[i+1])
        );
    end

    assign msb_sum   = sum_v[TOP];
    assign msb_b_eff = beff_v[TOP];

    logic unused_carry;
    assign unused_carry = carry[WIDTH];
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic             a_msb,
    input  logic             b_eff_msb,
    input  logic             sum_msb,
    input  logic [WIDTH-1:0] result,
    input  logic             arith,
    input  logic             wrap_mode,
    output logic             set_less,
    output logic             ovf,
    output logic             is_zero
);
    logic raw_ovf;

    always_comb begin
        raw_ovf  = (a_msb == b_eff_msb) && (sum_msb != a_msb);
        set_less = sum_msb ^ raw_ovf;
        ovf      = raw_ovf & arith & ~wrap_mode;
        is_zero  = ~|result;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_sel,
    input  logic             wrap_mode,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             ovf
);
    localparam int TOP = WIDTH - 1;

    ctrl_t            ctrl;
    logic             msb_sum;
    logic             msb_b_eff;
    logic             set_less;
    logic [WIDTH-1:0] less_vec;

    assign ctrl     = decode_op(op_sel);
    assign less_vec = {{(WIDTH-1){1'b0}}, set_less};

    alu_ripple #(.WIDTH(WIDTH)) u_ripple (
        .a         (opnd_a),
        .b         (opnd_b),
        .invert_b  (ctrl.invert_b),
        .pick      (ctrl.pick),
        .less      (less_vec),
        .res       (result),
        .msb_sum   (msb_sum),
        .msb_b_eff (msb_b_eff)
    );

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .a_msb     (opnd_a[TOP]),
        .b_eff_msb (msb_b_eff),
        .sum_msb   (msb_sum),
        .result    (result),
        .arith     (ctrl.arith),
        .wrap_mode (wrap_mode),
        .set_less  (set_less),
        .ovf       (ovf),
        .is_zero   (is_zero)
    );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_sel,
    input logic             wrap_mode,
    input logic [WIDTH-1:0] result,
    input logic             is_zero,
    input logic             ovf
);
    localparam int TOP = WIDTH - 1;

    always_comb begin
        p_no_overflow_r9: assert (!(wrap_mode && ovf));
        if (op_sel == 4'b0000)
            p_and_bits_r1: assert (result == (opnd_a & opnd_b));
        if (op_sel == 4'b0111)
            p_slt_upper_r5: assert (result[TOP:1] == '0);
        if (op_sel == 4'b0010 && opnd_a[TOP] != opnd_b[TOP])
            p_mixed_add_r8: assert (!ovf);
        if (op_sel == 4'b0110 && opnd_a[TOP] == opnd_b[TOP])
            p_same_sub_r8: assert (!ovf);
        if (op_sel != 4'b0010 && op_sel != 4'b0110)
            p_logic_noovf_r12: assert (!ovf);
        if (op_sel == 4'b0110 && opnd_a == opnd_b)
            p_self_sub_zero_r10: assert (is_zero);
    end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_core.sv
module sim_alu_core;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] a0, b0, r0;
    logic [3:0]  op0;
    logic        um0, z0, v0;
    logic [SW-1:0] a1, b1, r1;
    logic [3:0]    op1;
    logic          um1, z1, v1;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    alu_core #(.WIDTH(32)) u0 (
        .opnd_a(a0), .opnd_b(b0), .op_sel(op0), .wrap_mode(um0),
        .result(r0), .is_zero(z0), .ovf(v0)
    );
    alu_core #(.WIDTH(SW)) u1 (
        .opnd_a(a1), .opnd_b(b1), .op_sel(op1), .wrap_mode(um1),
        .result(r1), .is_zero(z1), .ovf(v1)
    );

    function automatic longint sx(input int w, input longint x);
        longint half = longint'(1) << (w - 1);
        return (x >= half) ? x - (half << 1) : x;
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic judge(input int w, input longint a, input longint b,
                         input logic [3:0] op, input logic um,
                         input longint got_r, input logic got_z, input logic got_v);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint sa = sx(w, a);
        longint sb = sx(w, b);
        longint er = 0;
        longint t;
        logic   ev = 1'b0;
        logic   ez;
        string  vt;
        case (op)
            4'b0000: er = a & b;
            4'b0001: er = a | b;
            4'b0010: begin er = (a + b) & mask; t = sa + sb; ev = !um && (t >= half || t < -half); end
            4'b0110: begin er = (a - b) & mask; t = sa - sb; ev = !um && (t >= half || t < -half); end
            4'b0111: er = (sa < sb) ? 1 : 0;
            default: er = 0;
        endcase
        ez = (er == 0);
        if (um) vt = "R9";
        else if (op == 4'b0010) vt = (sa < 0) != (sb < 0) ? "R8" : "R6";
        else if (op == 4'b0110) vt = (sa < 0) == (sb < 0) ? "R8" : "R7";
        else if (op == 4'b0000 || op == 4'b0001 || op == 4'b0111) vt = "R12";
        else vt = "R11";
        n_vec++;
        if (got_r != er || got_z != ez || got_v != ev) n_bad++;
        if (got_r != er)
            $display("FAIL %s result w=%0d op=%b um=%0b a=%0h b=%0h got %0h exp %0h",
                     res_tag(op), w, op, um, a, b, got_r, er);
        if (got_z != ez)
            $display("FAIL R10 is_zero w=%0d op=%b a=%0h b=%0h got %0b exp %0b",
                     w, op, a, b, got_z, ez);
        if (got_v != ev)
            $display("FAIL %s ovf w=%0d op=%b um=%0b a=%0h b=%0h got %0b exp %0b",
                     vt, w, op, um, a, b, got_v, ev);
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] op, input logic um);
        @(posedge clk);
        a0 = a; b0 = b; op0 = op; um0 = um;
        @(negedge clk);
        judge(32, longint'(a), longint'(b), op, um, longint'(r0), z0, v0);
    endtask

    task automatic apply4(input logic [SW-1:0] a, input logic [SW-1:0] b,
                          input logic [3:0] op, input logic um);
        @(posedge clk);
        a1 = a; b1 = b; op1 = op; um1 = um;
        @(negedge clk);
        judge(SW, longint'(a), longint'(b), op, um, longint'(r1), z1, v1);
    endtask

    logic [3:0]  ops [8]  = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b0011, 4'b1111, 4'b1000};
    logic [31:0] edge_v [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h5555_AAAA};

    initial begin
        a0 = '0; b0 = '0; op0 = 4'b0000; um0 = 1'b0;
        a1 = '0; b1 = '0; op1 = 4'b0000; um1 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: zero operands, AND code -> result 0, is_zero 1 (R10)
        @(negedge clk);
        judge(32, 0, 0, 4'b0000, 1'b0, longint'(r0), z0, v0);
        // directed: SLT overflow correction (R5), zero+ovf together (R6, R10)
        apply32(32'h8000_0000, 32'h0000_0001, 4'b0111, 1'b0);
        apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111, 1'b0);
        apply32(32'h8000_0000, 32'h8000_0000, 4'b0010, 1'b0);
        apply32(32'h8000_0000, 32'h8000_0000, 4'b0010, 1'b1);   // R9
        apply32(32'h7FFF_FFFF, 32'h8000_0000, 4'b0110, 1'b0);   // R7
        apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0010, 1'b0);   // R8
        // exhaustive small-width sweep over all listed codes and both modes
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 8; k++)
                for (int i = 0; i < (1 << SW); i++)
                    for (int j = 0; j < (1 << SW); j++)
                        apply4(SW'(i), SW'(j), ops[k], m[0]);
        // full-width corner operands
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 6; k++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        apply32(edge_v[i], edge_v[j], ops[k], m[0]);
        // full-width random operands
        for (int n = 0; n < 2000; n++)
            apply32($urandom, $urandom, ops[n % 6], n[3]);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule